// File: doc/BRIEF.md
# Phase-2 Clock Stretcher and Bank Decoder

This block derives the CPU phase-2 clock from a fast oscillator. On every oscillator edge the clock toggles, so an unstretched bus runs at half the oscillator rate. A 50 MHz oscillator therefore gives a 25 MHz bus.

During the low phase the CPU drives its bank byte on the data bus. The block samples that byte into a register, and the value stays frozen for the whole high phase. The latched bank and the live 16-bit address together pick one of three regions: RAM, ROM or I/O.

A ROM or I/O cycle holds the high phase for extra oscillator cycles, so the slow device gets more time to respond. The choice to stretch is fixed at the rising edge of the phase-2 clock. RAM cycles run at full speed.

Top module: `bus_clock_stretcher`

## Requirements
- R1: While `rst_n` is low, `phi2` inverts on every oscillator rising edge. During reset all three selects read 1 (inactive), `bank_out` reads 0 and `wait_active` reads 0.
- R2: A RAM cycle has a high phase of 1 oscillator cycle and a low phase of 1 oscillator cycle.
- R3: A ROM or I/O cycle has a high phase of 1+WAIT_OSC oscillator cycles, which is 3 by default. Its low phase stays at 1 cycle. At the default, the stretched cycle lasts two unstretched bus periods.
- R4: While `phi2` is low, `bank_out` follows `cpu_data`. The byte present at the rising edge of `phi2` is held on `bank_out` for the whole high phase, whatever `cpu_data` does afterwards.
- R5: Regions are decoded from the latched bank and the live address:
  - Bank 0x00 with address 0xFF00–0xFFFF is ROM.
  - Bank 0x00 with address 0xF000–0xFEFF is I/O.
  - Every other bank/address combination is RAM.
  - The selects `ram_cs_n`, `io_cs_n` and `rom_cs_n` are active low, and at most one is low at a time.
- R6: `rom_cs_n` goes low only when `cpu_rwb` is 1 (a read). A write that falls in the ROM region asserts no select, but the cycle is still stretched.
- R7: `wait_active` is 1 for exactly the high phase of a stretched cycle, and 0 at every other time.
- R8: The first cycle after reset fetches bank 0x00, address 0xFFFC. This cycle is decoded as ROM and stretched.
- R9: The stretch decision is taken at the rising edge of `phi2`. Moving the address to a RAM location partway through a stretched high phase does not shorten that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (carries the bank byte while `phi2` is low) |
| cpu_rwb | input | 1 | 1 = read, 0 = write |
| phi2 | output | 1 | Generated CPU phase-2 clock |
| bank_out | output | 8 | Latched bank byte (follows `cpu_data` while `phi2` is low) |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low, reads only |
| io_cs_n | output | 1 | I/O select, active low |
| wait_active | output | 1 | High during a stretched high phase |

## Verification
- **Driving:** Bus values are applied at an oscillator falling edge inside a low phase. At the next oscillator rising edge, `phi2` rises and the stretch decision is made.
- **Capture:** The first oscillator falling edge after that rise is where the monitor takes the bank, the selects and the wait flag. The low-phase transparency of `bank_out` is checked 1 ns after the drive, before the rising edge.
- **Length:** The monitor counts falling edges with `phi2` high until `phi2` drops. It expects 1 edge for a RAM cycle and 3 edges for a stretched cycle.
- **Scoring:** The driver queues one expected cycle per drive. The monitor compares the cycle when the high phase ends, so every comparison uses a cycle whose results are complete.

// File: rtl/bus_clock_stretcher.sv
module bus_clock_stretcher #(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 8,
  parameter int WAIT_OSC = 2,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hFF00,
  parameter logic [ADDR_W-1:0] IO_BASE  = 16'hF000,
  parameter logic [BANK_W-1:0] LOW_BANK = 8'h00
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BANK_W-1:0] cpu_data,
  input  logic              cpu_rwb,
  output logic              phi2,
  output logic [BANK_W-1:0] bank_out,
  output logic              ram_cs_n,
  output logic              rom_cs_n,
  output logic              io_cs_n,
  output logic              wait_active
);

  localparam int CW = (WAIT_OSC < 2) ? 1 : $clog2(WAIT_OSC + 1);

  typedef enum logic [1:0] {REG_RAM, REG_IO, REG_ROM} region_t;

  logic              phi2_q;
  logic              wait_q;
  logic [CW-1:0]     left_q;
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bank_eff;
  region_t           region;
  logic              stretch;

  assign bank_eff = phi2_q ? bank_q : cpu_data;

  always_comb begin
    region = REG_RAM;
    if (bank_eff == LOW_BANK) begin
      if (cpu_addr >= ROM_BASE)     region = REG_ROM;
      else if (cpu_addr >= IO_BASE) region = REG_IO;
    end
  end

  assign stretch = (region != REG_RAM);

  always_ff @(posedge clk_osc) begin
    if (!rst_n) begin
      if (phi2_q) phi2_q <= 1'b0;
      else        phi2_q <= 1'b1;
      wait_q <= 1'b0;
      left_q <= '0;
      bank_q <= '0;
    end else if (!phi2_q) begin
      phi2_q <= 1'b1;
      bank_q <= cpu_data;
      wait_q <= stretch;
      left_q <= stretch ? CW'(WAIT_OSC) : '0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      phi2_q <= 1'b0;
      wait_q <= 1'b0;
    end
  end

  assign phi2        = phi2_q;
  assign wait_active = wait_q;
  assign bank_out    = rst_n ? bank_eff : '0;
  assign ram_cs_n    = !(rst_n && region == REG_RAM);
  assign io_cs_n     = !(rst_n && region == REG_IO);
  assign rom_cs_n    = !(rst_n && region == REG_ROM && cpu_rwb);

  logic [CW:0] hi_run;
  always_ff @(posedge clk_osc) begin
    if (!phi2_q) hi_run <= '0;
    else         hi_run <= hi_run + 1'b1;
  end

  a_r3_high_length: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $fell(phi2_q) |-> ($past(hi_run) == '0 || $past(hi_run) == (CW+1)'(WAIT_OSC)));

  a_r7_wait_in_high: assert property (@(posedge clk_osc) disable iff (!rst_n)
    wait_q |-> phi2_q);

  a_r7_wait_ends_with_high: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $fell(wait_q) |-> $fell(phi2_q));

  a_r4_bank_hold: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (phi2_q && $past(phi2_q)) |-> $stable(bank_q));

  a_r5_one_select: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $countones({~ram_cs_n, ~io_cs_n, ~rom_cs_n}) <= 1);

  a_r2_ram_no_wait: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ($rose(phi2_q) && !ram_cs_n) |-> !wait_q);

endmodule

// File: tb/bus_clock_stretcher_bench.sv
module bus_clock_stretcher_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int         len;
    logic [7:0] bank;
    logic [2:0] sel;
    logic       wt;
    string      tag;
    string      seltag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_rwb = 1'b1;
  logic phi2, ram_cs_n, rom_cs_n, io_cs_n, wait_active;
  logic [7:0] bank_out;

  int vectors = 0;
  int fails = 0;
  bit mon_on = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_clock_stretcher u_bus_clock_stretcher (
    .clk_osc(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rwb(cpu_rwb), .phi2(phi2), .bank_out(bank_out), .ram_cs_n(ram_cs_n),
    .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n), .wait_active(wait_active));

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [7:0] bank, input logic [15:0] addr,
                                 input logic rwb, input string tag);
    exp_t e;
    e.bank = bank;
    e.tag = tag;
    if (bank == 8'h00 && addr >= 16'hFF00) begin
      e.len = 3; e.wt = 1'b1;
      e.sel = rwb ? 3'b011 : 3'b111;
      e.seltag = rwb ? "R5" : "R6";
    end else if (bank == 8'h00 && addr >= 16'hF000) begin
      e.len = 3; e.wt = 1'b1; e.sel = 3'b101; e.seltag = "R5";
    end else begin
      e.len = 1; e.wt = 1'b0; e.sel = 3'b110; e.seltag = "R5";
    end
    return e;
  endfunction

  task automatic drive_now(input logic [7:0] bank, input logic [15:0] addr,
                           input logic rwb, input bit move_addr, input string tag);
    cpu_data = bank;
    cpu_addr = addr;
    cpu_rwb  = rwb;
    q.push_back(model(bank, addr, rwb, tag));
    #1;
    check(bank_out == bank, "R4", "bank_out transparent in low phase", bank_out, bank);
    @(negedge clk);
    cpu_data = ~bank;
    if (move_addr) begin
      @(negedge clk);
      cpu_addr = 16'h1234;
    end
  endtask

  task automatic bus_cycle(input logic [7:0] bank, input logic [15:0] addr,
                           input logic rwb, input bit move_addr, input string tag);
    do @(negedge clk); while (phi2 !== 1'b0);
    drive_now(bank, addr, rwb, move_addr, tag);
  endtask

  logic prev_phi2 = 1'b0;
  bit   active = 0;
  int   run = 0;
  logic [7:0] cap_bank, last_bank;
  logic [2:0] cap_sel;
  logic cap_wt, last_wt;

  always @(negedge clk) begin
    if (mon_on) begin
      if (phi2 && !prev_phi2) begin
        active = (q.size() > 0);
        run = 1;
        cap_bank = bank_out;
        cap_sel = {rom_cs_n, io_cs_n, ram_cs_n};
        cap_wt = wait_active;
        last_bank = bank_out;
        last_wt = wait_active;
      end else if (phi2) begin
        run++;
        last_bank = bank_out;
        last_wt = wait_active;
      end else if (prev_phi2 && active) begin
        exp_t e;
        e = q.pop_front();
        active = 0;
        check(run == e.len, e.tag, "high phase length", run, e.len);
        check(cap_bank == e.bank && last_bank == e.bank, "R4", "bank held in high phase",
              last_bank, e.bank);
        check(cap_sel == e.sel, e.seltag, "selects {rom,io,ram}", cap_sel, e.sel);
        check(cap_wt == e.wt && last_wt == e.wt, "R7", "wait_active", last_wt, e.wt);
        check(!wait_active, "R7", "wait_active low after high phase", wait_active, 0);
      end
    end
    prev_phi2 = phi2;
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic last;
    @(negedge clk);
    last = phi2;
    for (int i = 0; i < 8; i++) begin
      cpu_data = 8'h5A;
      cpu_addr = 16'hFFFC;
      @(negedge clk);
      check(phi2 !== last, "R1", "phi2 toggles in reset", phi2, !last);
      check({rom_cs_n, io_cs_n, ram_cs_n} == 3'b111, "R1", "selects idle in reset",
            {rom_cs_n, io_cs_n, ram_cs_n}, 3'b111);
      check(bank_out == 8'h00 && wait_active == 1'b0, "R1", "bank/wait cleared in reset",
            {bank_out, wait_active}, 0);
      last = phi2;
    end
    while (phi2 !== 1'b0) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1;
    drive_now(8'h00, 16'hFFFC, 1'b1, 0, "R8");
    bus_cycle(8'h01, 16'h0000, 1'b1, 0, "R2");
    bus_cycle(8'h00, 16'hF000, 1'b0, 0, "R3");
    bus_cycle(8'h00, 16'hFEFF, 1'b1, 0, "R3");
    bus_cycle(8'h00, 16'hFF00, 1'b1, 0, "R3");
    bus_cycle(8'h00, 16'hEFFF, 1'b1, 0, "R2");
    bus_cycle(8'h00, 16'hFFF0, 1'b0, 0, "R6");
    bus_cycle(8'h02, 16'hFFFC, 1'b1, 0, "R2");
    bus_cycle(8'h00, 16'hFF10, 1'b1, 1, "R9");
    bus_cycle(8'hFF, 16'h1234, 1'b0, 0, "R2");
    for (int i = 0; i < 12; i++) begin
      logic [7:0]  b;
      logic [15:0] a;
      b = (i % 3 == 0) ? 8'h00 : 8'(i);
      a = 16'hE000 + 16'(i * 16'h0380);
      bus_cycle(b, a, 1'(i % 2), 0, a >= 16'hF000 && b == 8'h00 ? "R3" : "R2");
    end
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule